// File: doc/BRIEF.md
# Precision Time Counter with Fractional Addend

This block keeps a 64-bit nanosecond time of day for precision time protocol work. It is clocked by the reference clock. On every cycle in which counting is enabled, the free-running count grows by a whole number of nanoseconds (the period field). A 32-bit binary fraction (the addend) adds to an internal accumulator. Each carry out of that accumulator adds one more nanosecond, so software can trim the rate in parts per billion.

A second view, the synchronised time, is the free-running count plus a signed 64-bit correction, with wrap-around modulo 2^64. Software reaches the block through a small word-wide register port. On that port it sets the control word, the addend and the correction, preloads the counter, and reads either time as two 32-bit halves. Reading a low half freezes the matching high halves, so a 64-bit value is never torn across a carry.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, counting is off and the period field holds the reset default of 20. The addend, the correction, the preload words, the count and every time view read as zero.
- R2: While enabled, each clock adds the period plus the carry out of the 32-bit sum of fraction accumulator and addend (address 0x1) to the free-running count. The period is control word (address 0x0) bits [15:8]; the enable is bit 0.
- R3: While the enable bit is clear, the free-running count holds its value.
- R4: A write to preload low (0x4) is only staged. A write to preload high (0x5) sets the count to {high, staged low} on that edge, whether or not counting is enabled, and clears the fraction accumulator. Reads of 0x4/0x5 return the committed preload value.
- R5: A write to correction low (0x2) is staged and has no effect on the synchronised time. A write to correction high (0x3) commits {high, staged low}. The synchronised time is the count plus the committed correction, modulo 2^64. Reads of 0x2/0x3 return the committed correction.
- R6: A read strobe at free-running low (0x6) returns the live low word. On that edge it captures the whole count and the whole synchronised time. Addresses 0x7, 0x8 and 0x9 return the captured count high, synchronised low and synchronised high.
- R7: While enabled, current-time low (0x A) returns the live synchronised low word. A read strobe there captures the synchronised high word, which current-time high (0xB) returns until the next such strobe.
- R8: While disabled, 0xA and 0xB return the committed preload words instead of the current time, and a strobe at 0xA captures nothing.
- R9: The control word and the addend read back as written, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one count step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the word at addr |
| rd_en | input | 1 | Read strobe; triggers capture side effects |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |

## Verification
The reference model counts with a quarter-step addend, so a carry lands every fourth cycle. It also counts with an all-ones addend, where nearly every cycle carries, and with a zero addend, where no cycle does. These patterns separate a dropped, doubled or misplaced carry from correct behaviour. A preload just below a low-word rollover, followed by a capture and a late high-word read, shows whether shadowing and the 64-bit carry work. A correction larger than the count shows the modulo wrap of the synchronised time. The staged low writes and the disabled state are checked by reading the views they could disturb.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int DATA_W  = 32;
  localparam int TIME_W  = 64;
  localparam int FRAC_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int PER_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'h0,
    A_ADDEND  = 4'h1,
    A_OFS_LO  = 4'h2,
    A_OFS_HI  = 4'h3,
    A_LOAD_LO = 4'h4,
    A_LOAD_HI = 4'h5,
    A_FRT_LO  = 4'h6,
    A_FRT_HI  = 4'h7,
    A_SRT_LO  = 4'h8,
    A_SRT_HI  = 4'h9,
    A_CUR_LO  = 4'hA,
    A_CUR_HI  = 4'hB
  } reg_addr_e;
endpackage

// File: rtl/ptp_tod_cfg.sv
module ptp_tod_cfg
  import ptp_tod_pkg::*;
#(
  parameter int PERIOD_W   = 8,
  parameter int RST_PERIOD = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic                enable,
  output logic [PERIOD_W-1:0] period,
  output logic [FRAC_W-1:0]   addend,
  output logic [TIME_W-1:0]   offset,
  output logic [TIME_W-1:0]   load_val,
  output logic                load_cmd,
  output logic [TIME_W-1:0]   load_word
);
  logic                en_q, en_d;
  logic [PERIOD_W-1:0] per_q, per_d;
  logic [FRAC_W-1:0]   add_q, add_d;
  logic [DATA_W-1:0]   ofs_lo_q, ofs_lo_d;
  logic [TIME_W-1:0]   ofs_q, ofs_d;
  logic [DATA_W-1:0]   ld_lo_q, ld_lo_d;
  logic [TIME_W-1:0]   ld_q, ld_d;

  always_comb begin
    en_d     = en_q;
    per_d    = per_q;
    add_d    = add_q;
    ofs_lo_d = ofs_lo_q;
    ofs_d    = ofs_q;
    ld_lo_d  = ld_lo_q;
    ld_d     = ld_q;
    if (wr_en) begin
      case (addr)
        A_CTRL: begin
          en_d  = wdata[0];
          per_d = wdata[PER_LSB +: PERIOD_W];
        end
        A_ADDEND:  add_d    = wdata;
        A_OFS_LO:  ofs_lo_d = wdata;
        A_OFS_HI:  ofs_d    = {wdata, ofs_lo_q};
        A_LOAD_LO: ld_lo_d  = wdata;
        A_LOAD_HI: ld_d     = {wdata, ld_lo_q};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= PERIOD_W'(RST_PERIOD);
      add_q    <= '0;
      ofs_lo_q <= '0;
      ofs_q    <= '0;
      ld_lo_q  <= '0;
      ld_q     <= '0;
    end else begin
      en_q     <= en_d;
      per_q    <= per_d;
      add_q    <= add_d;
      ofs_lo_q <= ofs_lo_d;
      ofs_q    <= ofs_d;
      ld_lo_q  <= ld_lo_d;
      ld_q     <= ld_d;
    end
  end

  assign enable    = en_q;
  assign period    = per_q;
  assign addend    = add_q;
  assign offset    = ofs_q;
  assign load_val  = ld_q;
  assign load_cmd  = wr_en && (addr == A_LOAD_HI);
  assign load_word = {wdata, ld_lo_q};

  // R5: a staged low correction word never alters the committed correction
  p_ofs_commit_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_OFS_HI) |=> $stable(ofs_q));

  // R4: the committed preload changes only on a high-word write
  p_load_commit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cmd |=> $stable(ld_q));
endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum
  import ptp_tod_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  input  logic [FRAC_W-1:0]   addend,
  input  logic                load_cmd,
  input  logic [TIME_W-1:0]   load_word,
  output logic [TIME_W-1:0]   frt
);
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [TIME_W-1:0] frt_q, frt_d;
  logic [FRAC_W:0]   frac_sum;
  logic [TIME_W-1:0] step;

  assign frac_sum = {1'b0, frac_q} + {1'b0, addend};
  assign step     = TIME_W'(period) + TIME_W'(frac_sum[FRAC_W]);

  always_comb begin
    frac_d = frac_q;
    frt_d  = frt_q;
    if (load_cmd) begin
      frac_d = '0;
      frt_d  = load_word;
    end else if (enable) begin
      frac_d = frac_sum[FRAC_W-1:0];
      frt_d  = frt_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      frt_q  <= '0;
    end else begin
      frac_q <= frac_d;
      frt_q  <= frt_d;
    end
  end

  assign frt = frt_q;

  // R3: no movement while disabled and not preloaded
  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load_cmd) |=> $stable(frt_q));

  // R2: an enabled step is the period or the period plus one
  p_step_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load_cmd) |=>
      ((frt_q == $past(frt_q) + TIME_W'($past(period))) ||
       (frt_q == $past(frt_q) + TIME_W'($past(period)) + 64'd1)));

  // R4: a preload leaves the fraction empty and the count at the loaded word
  p_load_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd |=> (frac_q == '0) && (frt_q == $past(load_word)));
endmodule

// File: rtl/ptp_tod_readout.sv
module ptp_tod_readout
  import ptp_tod_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  input  logic [FRAC_W-1:0]   addend,
  input  logic [TIME_W-1:0]   offset,
  input  logic [TIME_W-1:0]   load_val,
  input  logic [TIME_W-1:0]   frt,
  input  logic [TIME_W-1:0]   srt,
  output logic [DATA_W-1:0]   rdata
);
  localparam int HALF = TIME_W / 2;

  logic [HALF-1:0]   frt_hi_q, frt_hi_d;
  logic [TIME_W-1:0] srt_sh_q, srt_sh_d;
  logic [HALF-1:0]   cur_hi_q, cur_hi_d;
  logic              cap_frt, cap_cur;

  assign cap_frt = rd_en && (addr == A_FRT_LO);
  assign cap_cur = rd_en && (addr == A_CUR_LO) && enable;

  always_comb begin
    frt_hi_d = frt_hi_q;
    srt_sh_d = srt_sh_q;
    cur_hi_d = cur_hi_q;
    if (cap_frt) begin
      frt_hi_d = frt[TIME_W-1:HALF];
      srt_sh_d = srt;
    end
    if (cap_cur) begin
      cur_hi_d = srt[TIME_W-1:HALF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frt_hi_q <= '0;
      srt_sh_q <= '0;
      cur_hi_q <= '0;
    end else begin
      frt_hi_q <= frt_hi_d;
      srt_sh_q <= srt_sh_d;
      cur_hi_q <= cur_hi_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:    rdata = (DATA_W'(period) << PER_LSB) | DATA_W'(enable);
      A_ADDEND:  rdata = addend;
      A_OFS_LO:  rdata = offset[HALF-1:0];
      A_OFS_HI:  rdata = offset[TIME_W-1:HALF];
      A_LOAD_LO: rdata = load_val[HALF-1:0];
      A_LOAD_HI: rdata = load_val[TIME_W-1:HALF];
      A_FRT_LO:  rdata = frt[HALF-1:0];
      A_FRT_HI:  rdata = frt_hi_q;
      A_SRT_LO:  rdata = srt_sh_q[HALF-1:0];
      A_SRT_HI:  rdata = srt_sh_q[TIME_W-1:HALF];
      A_CUR_LO:  rdata = enable ? srt[HALF-1:0] : load_val[HALF-1:0];
      A_CUR_HI:  rdata = enable ? cur_hi_q : load_val[TIME_W-1:HALF];
      default:   rdata = '0;
    endcase
  end

  // R6: a free-running low read freezes both 64-bit views as they stood
  p_frt_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_frt |=> (frt_hi_q == $past(frt[TIME_W-1:HALF])) && (srt_sh_q == $past(srt)));

  // R7: the current-time high shadow moves only on an enabled low read
  p_cur_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_cur |=> $stable(cur_hi_q));

  // R8: while disabled the current-time window shows the preload words
  p_cur_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && addr == A_CUR_HI) |-> (rdata == load_val[TIME_W-1:HALF]));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int PERIOD_W   = 8,
  parameter int RST_PERIOD = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [1:0]          rst_sync;
  logic                rst_int_n;
  logic                enable;
  logic [PERIOD_W-1:0] period;
  logic [FRAC_W-1:0]   addend;
  logic [TIME_W-1:0]   offset;
  logic [TIME_W-1:0]   load_val;
  logic                load_cmd;
  logic [TIME_W-1:0]   load_word;
  logic [TIME_W-1:0]   frt;
  logic [TIME_W-1:0]   srt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ptp_tod_cfg #(.PERIOD_W(PERIOD_W), .RST_PERIOD(RST_PERIOD)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .enable(enable), .period(period), .addend(addend), .offset(offset),
    .load_val(load_val), .load_cmd(load_cmd), .load_word(load_word)
  );

  ptp_tod_accum #(.PERIOD_W(PERIOD_W)) u_accum (
    .clk(clk), .rst_n(rst_int_n), .enable(enable), .period(period),
    .addend(addend), .load_cmd(load_cmd), .load_word(load_word), .frt(frt)
  );

  assign srt = frt + offset;

  ptp_tod_readout #(.PERIOD_W(PERIOD_W)) u_readout (
    .clk(clk), .rst_n(rst_int_n), .rd_en(rd_en), .addr(addr), .enable(enable),
    .period(period), .addend(addend), .offset(offset), .load_val(load_val),
    .frt(frt), .srt(srt), .rdata(rdata)
  );
endmodule

// File: tb/ptp_tod_counter_test.sv
module ptp_tod_counter_test;
  import ptp_tod_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // behavioural reference state
  logic [63:0] m_frt, m_off, m_load, m_ssh;
  logic [31:0] m_frac, m_add, m_off_lo, m_load_lo, m_fsh_hi, m_csh_hi;
  logic [7:0]  m_per;
  logic        m_en;

  ptp_tod_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] expect_word(input logic [3:0] a);
    logic [63:0] s;
    s = m_frt + m_off;
    case (a)
      4'h0: return {16'h0, m_per, 7'h0, m_en};
      4'h1: return m_add;
      4'h2: return m_off[31:0];
      4'h3: return m_off[63:32];
      4'h4: return m_load[31:0];
      4'h5: return m_load[63:32];
      4'h6: return m_frt[31:0];
      4'h7: return m_fsh_hi;
      4'h8: return m_ssh[31:0];
      4'h9: return m_ssh[63:32];
      4'hA: return m_en ? s[31:0] : m_load[31:0];
      4'hB: return m_en ? m_csh_hi : m_load[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic we, input logic re, input logic [3:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] exp;
    logic [32:0] sum;
    logic [63:0] s;
    wr_en = we; rd_en = re; addr = a; wdata = d;
    #1;
    exp = expect_word(a);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
    @(posedge clk);
    s = m_frt + m_off;
    if (re && a == 4'h6) begin m_fsh_hi = m_frt[63:32]; m_ssh = s; end
    if (re && a == 4'hA && m_en) m_csh_hi = s[63:32];
    if (we && a == 4'h5) begin
      m_frt = {d, m_load_lo}; m_frac = 32'h0;
    end else if (m_en) begin
      sum = {1'b0, m_frac} + {1'b0, m_add};
      m_frac = sum[31:0];
      m_frt = m_frt + 64'(m_per) + 64'(sum[32]);
    end
    if (we) begin
      case (a)
        4'h0: begin m_en = d[0]; m_per = d[15:8]; end
        4'h1: m_add = d;
        4'h2: m_off_lo = d;
        4'h3: m_off = {d, m_off_lo};
        4'h4: m_load_lo = d;
        4'h5: m_load = {d, m_load_lo};
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [3:0] a, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, a, 32'h0, tag);
  endtask

  initial begin
    m_frt = 0; m_off = 0; m_load = 0; m_ssh = 0; m_frac = 0; m_add = 0;
    m_off_lo = 0; m_load_lo = 0; m_fsh_hi = 0; m_csh_hi = 0; m_per = 8'd20; m_en = 0;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of every word
    for (int a = 0; a < 13; a++) step(1'b0, 1'b0, 4'(a), 32'h0, "R1");

    // R9: control and addend readback
    step(1'b1, 1'b0, 4'h1, 32'h4000_0000, "R9");
    step(1'b1, 1'b0, 4'h0, 32'h0000_1401, "R9");
    step(1'b0, 1'b0, 4'h0, 32'h0, "R9");
    step(1'b0, 1'b0, 4'h1, 32'h0, "R9");

    // R2: quarter-step addend, carry every fourth cycle
    idle(40, 4'h6, "R2");

    // R6: capture then late reads of the shadows
    step(1'b0, 1'b1, 4'h6, 32'h0, "R6");
    idle(10, 4'h6, "R6");
    step(1'b0, 1'b0, 4'h7, 32'h0, "R6");
    step(1'b0, 1'b0, 4'h8, 32'h0, "R6");
    step(1'b0, 1'b0, 4'h9, 32'h0, "R6");

    // R4: preload small value while enabled
    step(1'b1, 1'b0, 4'h4, 32'h0000_0010, "R4");
    step(1'b0, 1'b0, 4'h6, 32'h0, "R4");
    step(1'b1, 1'b0, 4'h5, 32'h0, "R4");
    step(1'b0, 1'b0, 4'h6, 32'h0, "R4");
    step(1'b0, 1'b0, 4'h4, 32'h0, "R4");

    // R5: staged low correction is ignored, then commit a negative one
    step(1'b1, 1'b0, 4'h2, 32'hFFFF_FF00, "R5");
    step(1'b0, 1'b0, 4'h2, 32'h0, "R5");
    step(1'b0, 1'b1, 4'h6, 32'h0, "R5");
    step(1'b0, 1'b0, 4'h8, 32'h0, "R5");
    step(1'b1, 1'b0, 4'h3, 32'hFFFF_FFFF, "R5");
    step(1'b0, 1'b1, 4'h6, 32'h0, "R5");
    step(1'b0, 1'b0, 4'h9, 32'h0, "R5");
    step(1'b0, 1'b0, 4'h8, 32'h0, "R5");
    step(1'b0, 1'b0, 4'h3, 32'h0, "R5");

    // R4: preload just below a low-word rollover; R6 coherent high across it
    step(1'b1, 1'b0, 4'h4, 32'hFFFF_FF00, "R4");
    step(1'b1, 1'b0, 4'h5, 32'h0000_0001, "R4");
    step(1'b0, 1'b1, 4'h6, 32'h0, "R6");
    idle(20, 4'h6, "R2");
    step(1'b0, 1'b0, 4'h7, 32'h0, "R6");
    step(1'b0, 1'b1, 4'h6, 32'h0, "R6");
    step(1'b0, 1'b0, 4'h7, 32'h0, "R6");

    // R2: all-ones addend, then zero addend with a new period
    step(1'b1, 1'b0, 4'h1, 32'hFFFF_FFFF, "R2");
    idle(12, 4'h6, "R2");
    step(1'b1, 1'b0, 4'h0, 32'h0000_0701, "R2");
    step(1'b1, 1'b0, 4'h1, 32'h0, "R2");
    idle(12, 4'h6, "R2");

    // R7: current-time view while enabled
    step(1'b0, 1'b1, 4'hA, 32'h0, "R7");
    idle(5, 4'hA, "R7");
    step(1'b0, 1'b0, 4'hB, 32'h0, "R7");

    // R3 / R8: disable, count holds, current view shows preload words
    step(1'b1, 1'b0, 4'h0, 32'h0000_0700, "R3");
    idle(8, 4'h6, "R3");
    step(1'b0, 1'b1, 4'hA, 32'h0, "R8");
    step(1'b0, 1'b0, 4'hB, 32'h0, "R8");
    step(1'b1, 1'b0, 4'h4, 32'h1234_5678, "R8");
    step(1'b1, 1'b0, 4'h5, 32'h0000_00AB, "R8");
    step(1'b0, 1'b0, 4'hA, 32'h0, "R8");
    step(1'b0, 1'b0, 4'hB, 32'h0, "R8");
    idle(4, 4'h6, "R3");

    // re-enable with a fractional addend and run on
    step(1'b1, 1'b0, 4'h1, 32'h8000_0001, "R2");
    step(1'b1, 1'b0, 4'h0, 32'h0000_1401, "R2");
    idle(30, 4'h6, "R2");
    step(1'b0, 1'b1, 4'hA, 32'h0, "R7");
    step(1'b0, 1'b0, 4'hB, 32'h0, "R7");
    step(1'b0, 1'b0, 4'hF, 32'h0, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule